// File: doc/BRIEF.md
# Prescaled Modulus Down-Counter with Underflow Flag

This block is a 16-bit down-counter that steps once per prescaled tick. A 2-bit select chooses the prescaler ratio from the set 1, 4, 8 and 16. Software writes a modulus value, which loads the counter at once. The counter then decrements toward zero. The tick that brings it to zero raises a sticky underflow flag. On the tick after that, the counter reloads the modulus and keeps running, so it produces a periodic event every (modulus + 1) ticks.

The flag can be cleared in one of two ways, chosen by a control bit. In normal mode it is write-one-to-clear. In fast-clear mode, writes to the flag are ignored, and a read strobe on the count register clears it instead. An interrupt request follows the flag while the interrupt-enable bit is set.

The block sits behind a small register bus with a 2-bit address, separate write and read strobes, and a combinational read path. The register map is as follows:

| Address | Read | Write |
|---|---|---|
| 0 | Control register | Control register |
| 1 | Live count | Modulus |
| 2 | Status register | Flag clear |
| 3 | Reads zero | No effect |

The control register holds the prescaler select in bits 1:0, the interrupt enable in bit 2 and the fast-clear mode in bit 3. The status register holds the flag in bit 0.

Top module: `moddown_ctr`

## Requirements
- R1: After reset, every register reads zero and `irq` is 0. With the reset modulus of zero, the flag stays clear.
- R2: Control bits 1:0 choose the prescale ratio: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. The count at address 1 drops by one every ratio clocks.
- R3: The status flag (address 2, bit 0) is set on the tick that moves the count from 1 to 0. With modulus M and ratio D, this happens M*D clocks after the modulus write. A modulus of 0 never sets the flag.
- R4: On the tick after the count reaches 0, the counter reloads the last written modulus and keeps counting.
- R5: A write to address 1 loads the counter on that clock edge and restarts the prescaler phase, so the first decrement follows exactly D clocks later.
- R6: With fast-clear mode off (control bit 3 = 0), writing status bit 0 = 1 clears the flag, and writing bit 0 = 0 leaves it unchanged.
- R7: With fast-clear mode on, a write of 1 to the flag does not clear it, and a read strobe at address 1 clears it. A read strobe at address 1 does not clear the flag while fast-clear mode is off.
- R8: Status bits 15:1, control bits 15:4 and every bit of address 3 read as zero.
- R9: `irq` is 1 exactly when the flag is 1 and interrupt enable (control bit 2) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effect only in fast-clear mode |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect on the clock edge that samples it. Read data is combinational, so the bench drives and samples on falling edges and reads a value one nanosecond after setting the address.

After a modulus write of M with ratio D, the count is due at M - floor(n/D) after n rising edges. The flag and `irq` are due at edge M*D, and the reload is due at edge (M+1)*D. The bench steps one falling edge at a time and compares against these closed forms on every cycle of the sweep over all four ratios and several moduli.

Clears and the fast-mode read act on the next edge, so their effect is checked at the falling edge after the strobe.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_RSVD  = 2'd3
  } mdc_addr_e;

  // Control register fields: bit3 fast-clear, bit2 irq enable, bits1:0 prescale select
  typedef struct packed {
    logic       fast;
    logic       ien;
    logic [1:0] psel;
  } mdc_ctrl_t;

  localparam int unsigned CTRL_W = 4;
  localparam int unsigned PRE_W  = 4;

  // Terminal phase value for each prescale select (ratio minus one)
  function automatic logic [PRE_W-1:0] psel_term(input logic [1:0] sel);
    logic [PRE_W-1:0] t;
    unique case (sel)
      2'b00:   t = PRE_W'(0);
      2'b01:   t = PRE_W'(3);
      2'b10:   t = PRE_W'(7);
      default: t = PRE_W'(15);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/mdc_prescaler.sv
module mdc_prescaler
  import mdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       tick
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] phase_d;
  logic [PRE_W-1:0] term;

  always_comb begin
    term = psel_term(psel);
    tick = (phase_q >= term);
    if (restart) begin
      phase_d = '0;
    end else if (tick) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/mdc_counter.sv
module mdc_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic [CW-1:0] modulus,
  output logic          zero_hit
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] mod_q, mod_d;
  logic          step;

  always_comb begin
    step     = tick && !load;
    zero_hit = step && (cnt_q == CW'(1));
    mod_d    = load ? load_val : mod_q;
    if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      cnt_d = (cnt_q == '0) ? mod_q : (cnt_q - CW'(1));
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mod_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      mod_q <= mod_d;
    end
  end

  assign count   = cnt_q;
  assign modulus = mod_q;

endmodule

// File: rtl/mdc_flag.sv
module mdc_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set,
  input  logic w1c_req,
  input  logic fast_mode,
  input  logic fast_rd_req,
  output logic flag
);

  logic flag_q, flag_d;
  logic clr;

  always_comb begin
    clr = fast_mode ? fast_rd_req : w1c_req;
    if (set) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/moddown_ctr.sv
module moddown_ctr
  import mdc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);

  // Reset synchronizer: asserts asynchronously, releases on clk
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe_q[1];

  // Control register
  mdc_ctrl_t ctrl_q, ctrl_d;
  logic      wr_ctrl, wr_mod, wr_stat, rd_count;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
    wr_mod   = bus_wr && (bus_addr == ADDR_COUNT);
    wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
    rd_count = bus_rd && (bus_addr == ADDR_COUNT);
    ctrl_d   = wr_ctrl ? mdc_ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  logic          tick;
  logic [CW-1:0] count, modulus;
  logic          zero_hit;
  logic          flag;

  mdc_prescaler u_pre (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .restart (wr_mod),
    .psel    (ctrl_q.psel),
    .tick    (tick)
  );

  mdc_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (wr_mod),
    .load_val (bus_wdata),
    .tick     (tick),
    .count    (count),
    .modulus  (modulus),
    .zero_hit (zero_hit)
  );

  mdc_flag u_flag (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .set         (zero_hit),
    .w1c_req     (wr_stat && bus_wdata[0]),
    .fast_mode   (ctrl_q.fast),
    .fast_rd_req (rd_count),
    .flag        (flag)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL:  bus_rdata = CW'(ctrl_q);
      ADDR_COUNT: bus_rdata = count;
      ADDR_STAT:  bus_rdata = CW'(flag);
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = flag && ctrl_q.ien;

endmodule

// File: rtl/mdc_chk.sv
module mdc_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          tick,
  input logic          load,
  input logic [CW-1:0] load_val,
  input logic [CW-1:0] count,
  input logic [CW-1:0] modulus,
  input logic          zero_hit,
  input logic          flag,
  input logic          fast,
  input logic          ien,
  input logic          irq,
  input logic          wr_stat,
  input logic          wdata0,
  input logic          rd_count
);

  // R2: an unloaded tick on a non-zero count decrements it by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !load && count != '0) |=> (count == $past(count) - CW'(1)));

  // R3: reaching zero raises the flag
  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_ni)
    zero_hit |=> flag);

  // R4: a tick at zero reloads the modulus
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !load && count == '0) |=> (count == $past(modulus)));

  // R5: a modulus write is visible in the count on the next cycle
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> (count == $past(load_val)));

  // R6: writing zero to the flag bit keeps it
  a_r6_w0_keeps: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag && wr_stat && !wdata0 && !rd_count) |=> flag);

  // R7: in fast-clear mode a write cannot clear the flag
  a_r7_fast_blocks_write: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag && fast && wr_stat && !rd_count) |=> flag);

  // R9: no request without enable
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_ni)
    !ien |-> !irq);

endmodule

bind moddown_ctr mdc_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_ni),
  .tick     (tick),
  .load     (wr_mod),
  .load_val (bus_wdata),
  .count    (count),
  .modulus  (modulus),
  .zero_hit (zero_hit),
  .flag     (flag),
  .fast     (ctrl_q.fast),
  .ien      (ctrl_q.ien),
  .irq      (irq),
  .wr_stat  (wr_stat),
  .wdata0   (bus_wdata[0]),
  .rd_count (rd_count)
);

// File: tb/moddown_ctr_tb.sv
`timescale 1ns/1ps
module moddown_ctr_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq;

  int tests;
  int fails;

  moddown_ctr u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_strobe(input logic [1:0] a);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int d;
    int m;
    int exp_cnt;
    tests = 0;
    fails = 0;
    bus_addr = 2'd0;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      chk("R1 reset read", v, 16'h0000);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);
    repeat (20) @(negedge clk);
    peek(2'd2, v);
    chk("R1 flag stays clear with zero modulus", v, 16'h0000);

    // R8: unused bits read zero
    wr(2'd0, 16'hFFF0);
    peek(2'd0, v);
    chk("R8 ctrl upper bits", v, 16'h0000);
    wr(2'd3, 16'hFFFF);
    peek(2'd3, v);
    chk("R8 addr3 reads zero", v, 16'h0000);

    // R2 R3 R4 R5 R9: sweep over prescale select and modulus
    for (int sel = 0; sel < 4; sel++) begin
      d = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 16;
      for (int k = 0; k < 5; k++) begin
        m = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 5 : 9;
        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'h0004 | 16'(sel));
        wr(2'd2, 16'h0001);
        wr(2'd1, 16'(m));
        peek(2'd1, v);
        chk("R5 immediate load", v, 16'(m));
        for (int n = 1; n <= (m + 1) * d; n++) begin
          @(negedge clk);
          exp_cnt = (n < (m + 1) * d) ? (m - n / d) : m;
          peek(2'd1, v);
          chk("R2 R4 R5 count", v, 16'(exp_cnt));
          peek(2'd2, v);
          chk("R3 flag", v, (n >= m * d) ? 16'h0001 : 16'h0000);
          chk("R9 irq follows flag", {15'd0, irq}, (n >= m * d) ? 16'h0001 : 16'h0000);
        end
      end
    end

    // Set the flag, then park the counter so it cannot set again
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0001);
    @(negedge clk);
    wr(2'd1, 16'hFFFF);
    peek(2'd2, v);
    chk("R3 flag set before clear tests", v, 16'h0001);
    chk("R9 irq off when disabled", {15'd0, irq}, 16'h0000);

    // R8: status upper bits
    peek(2'd2, v);
    chk("R8 status upper bits", v & 16'hFFFE, 16'h0000);

    // R6: write 0 keeps, write 1 clears
    wr(2'd2, 16'hFFFE);
    peek(2'd2, v);
    chk("R6 write zero keeps flag", v, 16'h0001);
    rd_strobe(2'd1);
    peek(2'd2, v);
    chk("R7 read strobe no clear in normal mode", v, 16'h0001);
    wr(2'd2, 16'h0001);
    peek(2'd2, v);
    chk("R6 write one clears", v, 16'h0000);

    // R7: fast-clear mode
    wr(2'd1, 16'h0001);
    @(negedge clk);
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'h000C);
    peek(2'd2, v);
    chk("R7 flag set in fast mode", v, 16'h0001);
    chk("R9 irq with enable", {15'd0, irq}, 16'h0001);
    wr(2'd2, 16'h0001);
    peek(2'd2, v);
    chk("R7 write one ignored in fast mode", v, 16'h0001);
    peek(2'd1, v);
    @(negedge clk);
    peek(2'd2, v);
    chk("R7 no clear without read strobe", v, 16'h0001);
    rd_strobe(2'd1);
    peek(2'd2, v);
    chk("R7 read strobe clears", v, 16'h0000);
    chk("R9 irq drops with flag", {15'd0, irq}, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule